// File: doc/BRIEF.md
# CRC-32C Multi-Width Step Unit

This block advances a running 32-bit CRC over the Castagnoli polynomial by one data chunk per request. A chunk is 8, 16, 32 or 64 bits wide, and the width is chosen with each request. The old CRC arrives in the low half of a 64-bit operand. The new CRC leaves zero-extended in a 64-bit result, so it can go straight back into the next request as the old value. A user covers a byte stream of any length by chaining steps. Wide steps take the bulk of the stream and narrow steps finish the tail.

The arithmetic is bit-reflected. Data bits are folded in starting from the least significant bit, so a multi-byte chunk is consumed lowest byte first. The unit never seeds or inverts the CRC. The caller supplies the starting value and applies any final inversion. Requests enter over a valid/ready handshake. Results leave from one register stage that accepts a new request on every cycle while the consumer keeps up.

Top module: `crc32c_step`

## Requirements
- R1: While `rst` is high and on the first cycle after it falls, `out_valid` is 0 and `in_ready` is 1.
- R2: An 8-bit step (`in_width` = 0) folds `in_data[7:0]` into the CRC one bit at a time, bit 0 first. For each bit, the CRC is shifted right by one, and if old CRC bit 0 XOR the data bit was 1, it is then XORed with 0x82F63B78.
- R3: A 16-bit step (`in_width` = 1) gives the same result as two chained 8-bit steps on `in_data[7:0]` and then `in_data[15:8]`.
- R4: A 32-bit step (`in_width` = 2) gives the same result as four chained 8-bit steps over `in_data[31:0]`, lowest byte first.
- R5: A 64-bit step (`in_width` = 3) gives the same result as eight chained 8-bit steps over `in_data[63:0]`, lowest byte first.
- R6: Data bits above the selected width have no effect on the result.
- R7: `in_crc[63:32]` has no effect on the result, and `out_crc[63:32]` is 0 whenever `out_valid` is 1.
- R8: The unit applies no seed and no inversion. Seeding 0xFFFFFFFF, chaining a 64-bit step on bytes "12345678" (data 0x3837363534333231) and an 8-bit step on "9" (0x39), then inverting, gives 0xE3069283.
- R9: A request accepted on a clock edge (`in_valid` and `in_ready` both 1) appears on `out_valid`/`out_crc` right after that edge.
- R10: While `out_valid` is 1 and `out_ready` is 0, `out_valid` stays 1, `out_crc` holds its value and `in_ready` is 0.
- R11: With `out_ready` held at 1, one request is accepted on every cycle. A result that is consumed with no new request behind it clears `out_valid` at that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Request present |
| in_ready | output | 1 | Unit can take a request this cycle |
| in_width | input | 2 | Chunk width: 0=8, 1=16, 2=32, 3=64 bits |
| in_crc | input | 64 | Old CRC in bits 31:0; bits 63:32 ignored |
| in_data | input | 64 | Data chunk, right-aligned |
| out_valid | output | 1 | Result present |
| out_ready | input | 1 | Consumer takes the result this cycle |
| out_crc | output | 64 | New CRC in bits 31:0, bits 63:32 zero |

## Verification
A result is due one cycle after its request is accepted. The bench drives a request on a falling edge and lets one rising edge accept it. It reads `out_crc` on the next falling edge and compares it with a byte-at-a-time reference model. Chains feed that sampled result back as the next old CRC. Under back-pressure the bench waits extra edges with `out_ready` low. It confirms that nothing moves during those cycles, then counts the single edge after `out_ready` rises before it checks the held request's result.

// File: rtl/crc32c_pkg.sv
package crc32c_pkg;

    localparam int CRC_W  = 32;
    localparam int DATA_W = 64;
    localparam int DEST_W = 64;
    localparam int N_WIDTHS = 4;
    localparam int SEL_W  = $clog2(N_WIDTHS);
    localparam logic [CRC_W-1:0] POLY_REFL = 32'h82F63B78;

    typedef enum logic [SEL_W-1:0] {
        CHUNK_8  = 2'd0,
        CHUNK_16 = 2'd1,
        CHUNK_32 = 2'd2,
        CHUNK_64 = 2'd3
    } chunk_e;

    typedef struct packed {
        chunk_e              width;
        logic [CRC_W-1:0]    crc;
        logic [DATA_W-1:0]   data;
    } step_req_t;

    // Reflected CRC update over the lowest nbits of d, bit 0 first
    function automatic logic [CRC_W-1:0] fold_bits(
        input logic [CRC_W-1:0]  crc,
        input logic [DATA_W-1:0] d,
        input int                nbits
    );
        logic [CRC_W-1:0] c;
        logic             fb;
        c = crc;
        for (int i = 0; i < DATA_W; i++) begin
            if (i < nbits) begin
                fb = c[0] ^ d[i];
                c  = c >> 1;
                if (fb) c = c ^ POLY_REFL;
            end
        end
        return c;
    endfunction

endpackage

// File: rtl/crc32c_fold.sv
module crc32c_fold
    import crc32c_pkg::*;
(
    input  step_req_t          req,
    output logic [DEST_W-1:0]  result
);
    logic [CRC_W-1:0] per_width [N_WIDTHS];

    for (genvar k = 0; k < N_WIDTHS; k++) begin : g_width
        localparam int NBITS = 8 << k;
        assign per_width[k] = fold_bits(req.crc, req.data, NBITS);
    end

    always_comb begin
        result = '0;
        result[CRC_W-1:0] = per_width[req.width];
    end
endmodule

// File: rtl/crc32c_stage.sv
module crc32c_stage
    import crc32c_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [DEST_W-1:0] d_result,
    output logic              out_valid,
    input  logic              out_ready,
    output logic [DEST_W-1:0] out_crc
);
    logic take;

    assign in_ready = !out_valid || out_ready;
    assign take     = in_valid && in_ready;

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            out_crc   <= '0;
        end else begin
            if (take) begin
                out_valid <= 1'b1;
                out_crc   <= d_result;
            end else if (out_ready) begin
                out_valid <= 1'b0;
            end
        end
    end

    p_hold_r10: assert property (@(posedge clk) disable iff (rst)
        out_valid && !out_ready |=> out_valid && $stable(out_crc));

    p_accept_r9: assert property (@(posedge clk) disable iff (rst)
        in_valid && in_ready |=> out_valid);

    p_drain_r11: assert property (@(posedge clk) disable iff (rst)
        out_valid && out_ready && !in_valid |=> !out_valid);

    p_upper_zero_r7: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> out_crc[DEST_W-1:CRC_W] == '0);

    p_stall_r10: assert property (@(posedge clk) disable iff (rst)
        out_valid && !out_ready |-> !in_ready);
endmodule

// File: rtl/crc32c_step.sv
module crc32c_step
    import crc32c_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [1:0]        in_width,
    input  logic [63:0]       in_crc,
    input  logic [63:0]       in_data,
    output logic              out_valid,
    input  logic              out_ready,
    output logic [63:0]       out_crc
);
    step_req_t         req;
    logic [DEST_W-1:0] folded;

    always_comb begin
        req.width = chunk_e'(in_width);
        req.crc   = in_crc[CRC_W-1:0];
        req.data  = in_data;
    end

    crc32c_fold u_fold (
        .req    (req),
        .result (folded)
    );

    crc32c_stage u_stage (
        .clk       (clk),
        .rst       (rst),
        .in_valid  (in_valid),
        .in_ready  (in_ready),
        .d_result  (folded),
        .out_valid (out_valid),
        .out_ready (out_ready),
        .out_crc   (out_crc)
    );
endmodule

// File: tb/crc32c_step_tb.sv
module crc32c_step_tb_top;
    logic        clk = 1'b0;
    logic        rst;
    logic        in_valid;
    logic        in_ready;
    logic [1:0]  in_width;
    logic [63:0] in_crc;
    logic [63:0] in_data;
    logic        out_valid;
    logic        out_ready;
    logic [63:0] out_crc;

    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;

    crc32c_step dut_i (
        .clk(clk), .rst(rst),
        .in_valid(in_valid), .in_ready(in_ready),
        .in_width(in_width), .in_crc(in_crc), .in_data(in_data),
        .out_valid(out_valid), .out_ready(out_ready), .out_crc(out_crc)
    );

    // Byte-at-a-time reference from the requirements
    function automatic logic [31:0] ref_crc(input logic [31:0] c0, input logic [63:0] d, input int nbytes);
        logic [31:0] c;
        c = c0;
        for (int b = 0; b < nbytes; b++) begin
            c = c ^ {24'h0, d[b*8 +: 8]};
            for (int j = 0; j < 8; j++)
                c = c[0] ? ((c >> 1) ^ 32'h82F63B78) : (c >> 1);
        end
        return c;
    endfunction

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // {width, old crc, data}
    localparam logic [129:0] VEC [0:9] = '{
        {2'd0, 64'h0000_0000_FFFF_FFFF, 64'h0000_0000_0000_0031},
        {2'd0, 64'h0000_0000_0000_0000, 64'h0000_0000_0000_0080},
        {2'd1, 64'h0000_0000_1234_5678, 64'h0000_0000_0000_A55A},
        {2'd1, 64'h0000_0000_FFFF_FFFF, 64'h0000_0000_0000_FFFF},
        {2'd2, 64'h0000_0000_DEAD_BEEF, 64'h0000_0000_0102_0304},
        {2'd2, 64'h0000_0000_0000_0001, 64'h0000_0000_FFFF_FFFF},
        {2'd3, 64'h0000_0000_FFFF_FFFF, 64'h3837_3635_3433_3231},
        {2'd3, 64'h0000_0000_8000_0000, 64'h0123_4567_89AB_CDEF},
        {2'd3, 64'h0000_0000_0000_0000, 64'h0000_0000_0000_0000},
        {2'd0, 64'h0000_0000_CAFE_F00D, 64'h0000_0000_0000_00FF}
    };

    // Drive at negedge, accepted at next posedge, sampled at following negedge
    task automatic step(input logic [1:0] w, input logic [63:0] c, input logic [63:0] d, output logic [63:0] res);
        in_valid = 1'b1; in_width = w; in_crc = c; in_data = d;
        @(posedge clk);
        @(negedge clk);
        in_valid = 1'b0;
        if (out_valid !== 1'b1) begin
            checks++; errors++;
            $display("FAIL R9 out_valid actual=%b expected=1", out_valid);
        end
        res = out_crc;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [63:0] r, r2;
        logic [31:0] m;
        rst = 1'b1; in_valid = 1'b0; in_width = '0; in_crc = '0; in_data = '0; out_ready = 1'b1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R1 out_valid in reset", {63'h0, out_valid}, 64'h0);
        rst = 1'b0;
        @(negedge clk);
        check("R1 out_valid after reset", {63'h0, out_valid}, 64'h0);
        check("R1 in_ready after reset", {63'h0, in_ready}, 64'h1);

        // Table walk: R2 (8-bit), R3 (16), R4 (32), R5 (64), R7 upper zero
        for (int i = 0; i < 10; i++) begin
            logic [1:0]  w;
            logic [63:0] c, d;
            int nb;
            w = VEC[i][129:128]; c = VEC[i][127:64]; d = VEC[i][63:0];
            nb = 1 << w;
            step(w, c, d, r);
            check($sformatf("R2/R3/R4/R5 vector %0d", i), r, {32'h0, ref_crc(c[31:0], d, nb)});
        end

        // R8: check value of "123456789"
        step(2'd3, 64'hFFFF_FFFF, 64'h3837_3635_3433_3231, r);
        step(2'd0, r, 64'h39, r);
        check("R8 check value", {32'h0, ~r[31:0]}, 64'hE306_9283);

        // R8 via 32,32,8 chain
        step(2'd2, 64'hFFFF_FFFF, 64'h3433_3231, r);
        step(2'd2, r, 64'h3837_3635, r);
        step(2'd0, r, 64'h39, r);
        check("R8 check value 32/32/8", {32'h0, ~r[31:0]}, 64'hE306_9283);

        // R3: 16-bit step equals two 8-bit steps
        step(2'd0, 64'h0BAD_CAFE, 64'h77, r);
        step(2'd0, r, 64'h99, r);
        step(2'd1, 64'h0BAD_CAFE, 64'h9977, r2);
        check("R3 16 vs 8+8", r2, r);

        // R6: garbage above the width is ignored
        step(2'd0, 64'h5555_AAAA, 64'hFFFF_FFFF_FFFF_FF12, r);
        check("R6 8-bit upper data ignored", r, {32'h0, ref_crc(32'h5555_AAAA, 64'h12, 1)});
        step(2'd2, 64'h5555_AAAA, 64'hDEAD_BEEF_0BAD_F00D, r);
        check("R6 32-bit upper data ignored", r, {32'h0, ref_crc(32'h5555_AAAA, 64'h0BAD_F00D, 4)});

        // R7: upper old-CRC bits ignored, upper result bits zero
        step(2'd1, 64'hFFFF_FFFF_1357_9BDF, 64'h4242, r);
        check("R7 upper crc ignored", r, {32'h0, ref_crc(32'h1357_9BDF, 64'h4242, 2)});

        // R11: back-to-back, one per cycle
        out_ready = 1'b1;
        in_valid = 1'b1; in_width = 2'd2; in_crc = 64'h1111_2222; in_data = 64'hA1B2_C3D4;
        @(posedge clk);
        @(negedge clk);
        check("R11 first result", out_crc, {32'h0, ref_crc(32'h1111_2222, 64'hA1B2_C3D4, 4)});
        check("R11 in_ready while streaming", {63'h0, in_ready}, 64'h1);
        in_width = 2'd3; in_crc = out_crc; in_data = 64'h0F1E_2D3C_4B5A_6978;
        m = ref_crc(out_crc[31:0], 64'h0F1E_2D3C_4B5A_6978, 8);
        @(posedge clk);
        @(negedge clk);
        in_valid = 1'b0;
        check("R11 second result", out_crc, {32'h0, m});
        @(posedge clk);
        @(negedge clk);
        check("R11 drained", {63'h0, out_valid}, 64'h0);

        // R10: back-pressure holds the result and blocks input
        out_ready = 1'b0;
        in_valid = 1'b1; in_width = 2'd0; in_crc = 64'h0000_1234; in_data = 64'hAB;
        @(posedge clk);
        @(negedge clk);
        r = out_crc;
        check("R10 first under stall", r, {32'h0, ref_crc(32'h0000_1234, 64'hAB, 1)});
        check("R10 in_ready low", {63'h0, in_ready}, 64'h0);
        in_width = 2'd1; in_crc = 64'h0000_5678; in_data = 64'hCDEF;
        repeat (2) @(posedge clk);
        @(negedge clk);
        check("R10 out_crc held", out_crc, r);
        check("R10 out_valid held", {63'h0, out_valid}, 64'h1);
        out_ready = 1'b1;
        @(posedge clk);
        @(negedge clk);
        in_valid = 1'b0;
        check("R10 held request delivered", out_crc, {32'h0, ref_crc(32'h0000_5678, 64'hCDEF, 2)});
        @(posedge clk);
        @(negedge clk);
        check("R11 drained after stall", {63'h0, out_valid}, 64'h0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule